// File: doc/BRIEF.md
# Triggered One-Shot Delay Timer

This block is a single timer channel that measures out a programmed delay and then raises a one-cycle interrupt. Software first arms the channel with a start strobe. The channel then waits for a start event. A start event is either a chosen transition on an external trigger pin or a second start strobe issued while the channel is already armed. On that event the channel copies a 16-bit reload register into its counter and counts down by one on each selected count tick. When the counter has run out, the channel pulses the interrupt and goes idle until the next start event.

The trigger pin is brought into the clock domain through a flop chain. An optional three-sample filter rejects short pulses. Edge detection can then follow rising edges, falling edges or both. The count tick is taken from one of four prescaled tick inputs that are generated outside the block. The reload register can be written at any time. A countdown already in progress keeps the value it started with.

Top module: `dly_oneshot_timer`

## Requirements
- R1: After reset, `armed` is 0 and `irq` is 0.
- R2: A `start_cmd` pulse on a disarmed channel sets `armed` on the next cycle and does not begin a countdown, so no interrupt follows.
- R3: While armed, with the filter off and the selected tick high every cycle, a valid trigger transition on `trig_in` produces `irq` (reload + 5) clock cycles after the cycle in which `trig_in` changed.
- R4: `irq` is high for exactly one cycle per countdown. After it the counter stays idle and raises no further interrupt until a new start event.
- R5: `edge_mode` encodings: 2'b00 accepts rising transitions only, 2'b01 accepts falling transitions only, 2'b10 and 2'b11 accept both. Transitions of the other polarity have no effect.
- R6: With `filt_en` = 1, a new trigger level is accepted only after it has been sampled equal three cycles in a row. A pulse of two cycles or less is ignored, and an accepted transition yields `irq` (reload + 8) cycles after the pin change.
- R7: A `start_cmd` pulse on an armed channel starts a countdown with no pin activity. `irq` follows (reload + 2) cycles after the strobe cycle when the tick is high every cycle.
- R8: Writing `reload_data` with `reload_wr` during a countdown leaves that countdown unchanged. The next start event uses the new value.
- R9: A start event during a countdown restarts it from the reload register. If the start event falls in the same cycle as the final tick, the restart wins and that interrupt is not raised.
- R10: A `stop_cmd` pulse clears `armed` and cancels any countdown without an interrupt. While disarmed, trigger transitions are ignored. When `stop_cmd` and `start_cmd` are high in the same cycle, stop wins.
- R11: The counter moves only on `tick_src[tick_sel]`. While the selected source is low, the count holds, and the countdown resumes when a ticking source is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_data | input | 16 | Reload value written on `reload_wr` |
| start_cmd | input | 1 | Arm strobe; on an armed channel it also starts a countdown |
| stop_cmd | input | 1 | Disarm strobe; cancels any countdown |
| tick_src | input | 4 | Four prescaled count-tick sources |
| tick_sel | input | 2 | Index of the tick source that drives the counter |
| trig_in | input | 1 | Asynchronous external trigger pin |
| filt_en | input | 1 | Enables the three-sample trigger filter |
| edge_mode | input | 2 | Trigger polarity: 00 rising, 01 falling, 1x both |
| armed | output | 1 | Channel armed status |
| irq | output | 1 | One-cycle interrupt pulse at the end of the delay |

## Verification
The key coincidence is a start event in the same cycle as the countdown's last tick, where a restart and an expiry compete. The bench arms a countdown, then times a second software start so that it is sampled exactly on the edge that would otherwise raise the interrupt. The scoreboard then expects only the interrupt of the restarted delay, and any early pulse shows up as a cycle mismatch. The other coincidence is a stop strobe and a start strobe in the same cycle. It is judged by reading `armed` afterwards and by the absence of any interrupt.

// File: rtl/dly_pkg.sv
package dly_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE     = 2'b00,
        EDGE_FALL     = 2'b01,
        EDGE_BOTH     = 2'b10,
        EDGE_BOTH_ALT = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic abort;
        logic load;
        logic tick;
    } ctr_cmd_t;

    function automatic logic edge_hit(edge_mode_e mode, logic cur, logic prv);
        case (mode)
            EDGE_RISE: return cur & ~prv;
            EDGE_FALL: return ~cur & prv;
            default:   return cur ^ prv;
        endcase
    endfunction

endpackage

// File: rtl/dly_trig_cond.sv
module dly_trig_cond
    import dly_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       trig_in,
    input  logic       filt_en,
    input  edge_mode_e edge_mode,
    output logic       edge_seen
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   lvl_q;
    logic                   prev_q;
    logic                   sync_lvl;

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            hist_q <= '0;
            lvl_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_lvl};
            prev_q <= lvl_q;
            if (!filt_en)
                lvl_q <= sync_lvl;
            else if (&hist_q)
                lvl_q <= 1'b1;
            else if (~|hist_q)
                lvl_q <= 1'b0;
        end
    end

    assign edge_seen = edge_hit(edge_mode, lvl_q, prev_q);

endmodule

// File: rtl/dly_tick_sel.sv
module dly_tick_sel #(
    parameter int NUM_SRC = 4,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic [SEL_W-1:0]   tick_sel,
    output logic               tick
);
    assign tick = tick_src[tick_sel];
endmodule

// File: rtl/dly_down_ctr.sv
module dly_down_ctr
    import dly_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctr_cmd_t         cmd,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (cmd.abort) begin
                run_q <= 1'b0;
            end else if (cmd.load) begin
                cnt_q <= load_val;
                run_q <= 1'b1;
            end else if (run_q && cmd.tick) begin
                if (cnt_q == '0) begin
                    run_q <= 1'b0;
                    exp_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign count  = cnt_q;
    assign expire = exp_q;

endmodule

// File: rtl/dly_oneshot_timer.sv
module dly_oneshot_timer
    import dly_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    localparam int SEL_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reload_wr,
    input  logic [CNT_W-1:0]   reload_data,
    input  logic               start_cmd,
    input  logic               stop_cmd,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic [SEL_W-1:0]   tick_sel,
    input  logic               trig_in,
    input  logic               filt_en,
    input  logic [1:0]         edge_mode,
    output logic               armed,
    output logic               irq
);
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_val;
    logic             armed_q;
    logic             edge_seen;
    logic             sel_tick;
    logic             ctr_load;
    ctr_cmd_t         ctr_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            if (reload_wr)
                reload_q <= reload_data;
            if (stop_cmd)
                armed_q <= 1'b0;
            else if (start_cmd)
                armed_q <= 1'b1;
        end
    end

    dly_trig_cond #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_trig (
        .clk      (clk),
        .rst      (rst),
        .trig_in  (trig_in),
        .filt_en  (filt_en),
        .edge_mode(edge_mode_e'(edge_mode)),
        .edge_seen(edge_seen)
    );

    dly_tick_sel #(.NUM_SRC(NUM_SRC)) u_tick (
        .tick_src(tick_src),
        .tick_sel(tick_sel),
        .tick    (sel_tick)
    );

    assign ctr_load = armed_q && !stop_cmd && (start_cmd || edge_seen);

    always_comb begin
        ctr_cmd.abort = stop_cmd;
        ctr_cmd.load  = ctr_load;
        ctr_cmd.tick  = sel_tick;
    end

    dly_down_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .cmd     (ctr_cmd),
        .load_val(reload_q),
        .count   (cnt_val),
        .expire  (irq)
    );

    assign armed = armed_q;

endmodule

// File: rtl/dly_oneshot_timer_chk.sv
module dly_oneshot_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start_cmd,
    input logic             stop_cmd,
    input logic             armed,
    input logic             irq,
    input logic             ctr_load,
    input logic             sel_tick,
    input logic [CNT_W-1:0] cnt_val
);
    assert_start_arms_R2: assert property (@(posedge clk) disable iff (rst)
        (start_cmd && !stop_cmd) |=> armed);

    assert_irq_single_R4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    assert_stop_clears_R10: assert property (@(posedge clk) disable iff (rst)
        stop_cmd |=> (!armed && !irq));

    assert_disarmed_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !irq);

    assert_count_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (!sel_tick && !ctr_load) |=> $stable(cnt_val));
endmodule

bind dly_oneshot_timer dly_oneshot_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_cmd(start_cmd),
    .stop_cmd (stop_cmd),
    .armed    (armed),
    .irq      (irq),
    .ctr_load (ctr_load),
    .sel_tick (sel_tick),
    .cnt_val  (cnt_val)
);

// File: tb/dly_oneshot_timer_tb.sv
module dly_oneshot_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reload_wr = 1'b0;
    logic [15:0] reload_data = '0;
    logic        start_cmd = 1'b0;
    logic        stop_cmd = 1'b0;
    logic [3:0]  tick_src;
    logic [1:0]  tick_sel = 2'd0;
    logic        trig_in = 1'b0;
    logic        filt_en = 1'b0;
    logic [1:0]  edge_mode = 2'b00;
    logic        armed;
    logic        irq;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    int    exp_q[$];

    assign tick_src = 4'b0011;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dly_oneshot_timer u_dut (
        .clk(clk), .rst(rst), .reload_wr(reload_wr), .reload_data(reload_data),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .tick_src(tick_src),
        .tick_sel(tick_sel), .trig_in(trig_in), .filt_en(filt_en),
        .edge_mode(edge_mode), .armed(armed), .irq(irq)
    );

    // monitor: every interrupt pulse must match the head of the scoreboard
    always @(negedge clk) begin
        if (!rst && irq && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s: irq at cycle %0d, expected none", cur_req, cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    fails++;
                    $display("FAIL %s: irq at cycle %0d, expected cycle %0d", cur_req, cyc, e);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_val(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drain(input int n);
        step(n);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL %s: missing irq, actual %0d pending expected 0", cur_req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic sw_start();
        start_cmd = 1'b1;
        step(1);
        start_cmd = 1'b0;
    endtask

    task automatic write_reload(input int v);
        reload_wr = 1'b1;
        reload_data = 16'(v);
        step(1);
        reload_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        step(200000);
        fails++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        int d;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        cur_req = "R1";
        check_val("R1", armed, 0, "armed after reset");
        check_val("R1", irq, 0, "irq after reset");

        // R2 arming does not start a count
        cur_req = "R2";
        write_reload(5);
        sw_start();
        check_val("R2", armed, 1, "armed after start");
        drain(20);

        // R7 software start while armed, R4 single pulse
        cur_req = "R7";
        c = cyc;
        exp_q.push_back(c + 5 + 2);
        sw_start();
        drain(20);

        // R3 rising edge, unfiltered
        cur_req = "R3";
        write_reload(7);
        c = cyc;
        exp_q.push_back(c + 7 + 5);
        trig_in = 1'b1;
        drain(20);
        // R5 falling ignored in rising mode
        cur_req = "R5";
        trig_in = 1'b0;
        drain(20);

        // R5 falling mode
        edge_mode = 2'b01;
        trig_in = 1'b1;
        drain(20);
        c = cyc;
        exp_q.push_back(c + 7 + 5);
        trig_in = 1'b0;
        drain(20);

        // R5 both-edge mode
        edge_mode = 2'b10;
        c = cyc;
        exp_q.push_back(c + 7 + 5);
        trig_in = 1'b1;
        drain(20);
        c = cyc;
        exp_q.push_back(c + 7 + 5);
        trig_in = 1'b0;
        drain(20);

        // R6 filter rejects a two-cycle pulse, accepts a steady level
        cur_req = "R6";
        edge_mode = 2'b00;
        filt_en = 1'b1;
        trig_in = 1'b1;
        step(2);
        trig_in = 1'b0;
        drain(20);
        c = cyc;
        exp_q.push_back(c + 7 + 8);
        trig_in = 1'b1;
        drain(25);
        trig_in = 1'b0;
        drain(20);
        // same short pulse passes with the filter off
        filt_en = 1'b0;
        c = cyc;
        exp_q.push_back(c + 7 + 5);
        trig_in = 1'b1;
        step(2);
        trig_in = 1'b0;
        drain(20);

        // R8 reload written mid-count applies to the next start only
        cur_req = "R8";
        c = cyc;
        exp_q.push_back(c + 7 + 2);
        sw_start();
        write_reload(3);
        drain(15);
        c = cyc;
        exp_q.push_back(c + 3 + 2);
        sw_start();
        drain(15);

        // R9 restart mid-count
        cur_req = "R9";
        write_reload(10);
        sw_start();
        step(3);
        c = cyc;
        exp_q.push_back(c + 10 + 2);
        sw_start();
        drain(25);
        // R9 restart on the final tick: restart wins
        write_reload(6);
        c = cyc;
        sw_start();
        step(6);
        d = cyc;
        check_val("R9", d, c + 7, "restart strobe cycle");
        exp_q.push_back(d + 6 + 2);
        sw_start();
        drain(20);

        // R11 count holds on an idle tick source
        cur_req = "R11";
        write_reload(4);
        tick_sel = 2'd2;
        sw_start();
        drain(10);
        d = cyc;
        exp_q.push_back(d + 4 + 1);
        tick_sel = 2'd0;
        drain(15);
        // source 1 also ticks every cycle
        tick_sel = 2'd1;
        c = cyc;
        exp_q.push_back(c + 4 + 2);
        sw_start();
        drain(15);
        tick_sel = 2'd0;

        // R10 stop aborts, disarms, and blocks edges
        cur_req = "R10";
        write_reload(9);
        sw_start();
        step(3);
        stop_cmd = 1'b1;
        step(1);
        stop_cmd = 1'b0;
        check_val("R10", armed, 0, "armed after stop");
        drain(20);
        edge_mode = 2'b10;
        trig_in = 1'b1;
        step(8);
        trig_in = 1'b0;
        drain(20);
        // stop beats start in the same cycle
        start_cmd = 1'b1;
        stop_cmd = 1'b1;
        step(1);
        start_cmd = 1'b0;
        stop_cmd = 1'b0;
        check_val("R10", armed, 0, "armed after stop with start");
        drain(15);
        // R2 start on a disarmed channel only arms it
        cur_req = "R2";
        sw_start();
        check_val("R2", armed, 1, "armed after re-arm");
        drain(20);

        finish_run();
    end
endmodule